// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

One counter/timer channel, configured entirely through a byte-wide write strobe. Each byte written falls into one of three kinds: a configuration word, an interrupt vector, or a reload value. A configuration word can announce that the byte after it is a reload value. That byte is then taken as a reload value whatever its low bit holds.

The channel has two counting modes. In event-count mode, the down-counter steps once on each selected edge of an external trigger line. In interval mode, a divide-by-16 or divide-by-256 prescaler runs from the system clock and steps the down-counter. Interval mode can start as soon as a reload value arrives, or it can wait for an edge on the trigger line.

When the counter reaches zero, the channel raises a one-cycle terminal pulse and reloads from the stored reload value. If interrupts are enabled, it also latches an interrupt request, which stays high until it is acknowledged. The stored vector is always present on an output for the interrupt responder to read.

Top module: `tmr_chan_top`

## Requirements
- R1: After the synchronous reset, `term_pulse`, `irq_req` and `vector` are all 0. The channel stays stopped, so no terminal pulse appears until a reload value has been written.
- R2: A written byte with bit 0 = 0 is stored as the vector and appears on `vector` one cycle after the write, except when a reload value is due.
- R3: A written byte with bit 0 = 1 is a configuration word. When its bit 2 is 1, the next written byte is taken as the reload value regardless of its bit 0. That byte does not change `vector` or the configuration.
- R4: Configuration bit 6 = 0 selects interval mode. The prescale factor is P = 16 when bit 5 = 0 and P = 256 when bit 5 = 1. With reload value N, where N = 0 means 256, `term_pulse` goes high for exactly one cycle, P×N cycles after the reload write, and then every P×N cycles after that.
- R5: Configuration bit 6 = 1 selects event-count mode. Each active edge of `ext_trig` decrements the count; bit 4 = 1 selects rising edges and bit 4 = 0 selects falling edges. `term_pulse` goes high in the cycle after the clock that samples the N-th active edge.
- R6: In interval mode with configuration bit 3 = 1, loading a reload value does not start counting. Counting starts at the clock that samples an active edge of `ext_trig`, and the first pulse comes P×N cycles after that clock.
- R7: With configuration bit 7 = 1, each terminal count sets `irq_req` in the same cycle as `term_pulse`. `irq_req` stays high until `int_ack` is sampled high. With bit 7 = 0, `irq_req` stays 0.
- R8: Writing a configuration word with bit 7 = 1 does not raise `irq_req` for a terminal count that occurred before the write.
- R9: A configuration word with bit 1 = 1 stops the channel. No terminal pulse appears until a new reload value has been written.
- R10: A reload value written while the channel is counting does not disturb the current period. It is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Configuration word, vector or reload value |
| ext_trig | input | 1 | External event / start trigger line |
| int_ack | input | 1 | Clears a pending interrupt request |
| term_pulse | output | 1 | One-cycle terminal-count pulse |
| irq_req | output | 1 | Pending interrupt request |
| vector | output | 8 | Stored interrupt vector |

## Verification
Every output is registered, so all results are due exactly one cycle after the clock that causes them. A vector write shows on `vector` one cycle later. The first interval pulse comes P×N cycles after the reload write, or P×N cycles after the clock that samples the trigger edge. An event-mode pulse comes one cycle after the clock that samples the N-th edge. The bench drives inputs and samples outputs on falling clock edges. It counts falling edges from the stimulus to each expected pulse, so every measured gap matches these cycle counts exactly. A behavioural model that advances on each rising edge is also compared with all three outputs on every falling edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic irq_en;
        logic ext_count;
        logic long_pre;
        logic rise_sel;
        logic trig_start;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } chan_state_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_CFG  = 2'd1,
        WR_VEC  = 2'd2,
        WR_TC   = 2'd3
    } wr_kind_t;

    function automatic chan_cfg_t cfg_from_byte(input logic [BYTE_W-1:0] b);
        chan_cfg_t c;
        c.irq_en     = b[7];
        c.ext_count  = b[6];
        c.long_pre   = b[5];
        c.rise_sel   = b[4];
        c.trig_start = b[3];
        return c;
    endfunction

    function automatic wr_kind_t classify(input logic wr, input logic tc_due, input logic b0);
        if (!wr)
            return WR_NONE;
        else if (tc_due)
            return WR_TC;
        else if (b0)
            return WR_CFG;
        else
            return WR_VEC;
    endfunction

endpackage

// File: rtl/tmr_wr_decode.sv
module tmr_wr_decode
    import tmr_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output chan_cfg_t         cfg,
    output logic [BYTE_W-1:0] vec_q,
    output logic [BYTE_W-1:0] tc_q,
    output logic              tc_load,
    output logic              sw_stop
);

    logic     tc_due_q;
    wr_kind_t kind;

    assign kind    = classify(wr_en, tc_due_q, wr_data[0]);
    assign tc_load = (kind == WR_TC);
    assign sw_stop = (kind == WR_CFG) && wr_data[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            vec_q    <= '0;
            tc_q     <= '0;
            tc_due_q <= 1'b0;
        end else begin
            case (kind)
                WR_TC: begin
                    tc_q     <= wr_data;
                    tc_due_q <= 1'b0;
                end
                WR_CFG: begin
                    cfg      <= cfg_from_byte(wr_data);
                    tc_due_q <= wr_data[2];
                end
                WR_VEC:  vec_q <= wr_data;
                default: ;
            endcase
        end
    end

    // R2
    vec_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tc_due_q && !wr_data[0]) |=> (vec_q == $past(wr_data)));

    // R3
    tc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tc_due_q) |=> (tc_q == $past(wr_data)) && !tc_due_q && $stable(vec_q));

endmodule

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic rise_sel,
    output logic edge_hit
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= trig_in;
    end

    assign edge_hit = rise_sel ? (trig_in && !prev_q) : (!trig_in && prev_q);

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SHORT_DIV = 16,
    parameter int LONG_DIV  = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic long_pre,
    output logic tick
);

    localparam int PW = $clog2(LONG_DIV);
    localparam logic [PW-1:0] SHORT_LAST = PW'(SHORT_DIV - 1);
    localparam logic [PW-1:0] LONG_LAST  = PW'(LONG_DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && (phase_q == (long_pre ? LONG_LAST : SHORT_LAST));

    always_ff @(posedge clk) begin
        if (rst || !run) phase_q <= '0;
        else if (tick)   phase_q <= '0;
        else             phase_q <= phase_q + 1'b1;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_en,
    input  logic             ext_count,
    input  logic             trig_start,
    input  logic             edge_hit,
    input  logic             pre_tick,
    input  logic             tc_load,
    input  logic [CNT_W-1:0] tc_new,
    input  logic [CNT_W-1:0] tc_reload,
    input  logic             sw_stop,
    input  logic             int_ack,
    output logic             timer_run,
    output logic             zc_q,
    output logic             irq_q
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    chan_state_t      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             zero;

    assign timer_run = (st_q == CH_RUN) && !ext_count;
    assign step      = (st_q == CH_RUN) && (ext_count ? edge_hit : pre_tick);
    assign zero      = step && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
        end else if (sw_stop) begin
            st_q <= CH_IDLE;
        end else begin
            case (st_q)
                CH_IDLE: if (tc_load) begin
                    cnt_q <= tc_new;
                    st_q  <= (!ext_count && trig_start) ? CH_ARMED : CH_RUN;
                end
                CH_ARMED: if (edge_hit) st_q <= CH_RUN;
                CH_RUN:   if (step) cnt_q <= zero ? tc_reload : cnt_q - 1'b1;
                default:  st_q <= CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zc_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            zc_q <= zero;
            if (zero && irq_en) irq_q <= 1'b1;
            else if (int_ack)   irq_q <= 1'b0;
        end
    end

    // R4
    zc_single_chk: assert property (@(posedge clk) disable iff (rst)
        zc_q |=> !zc_q);

    // R9
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CH_IDLE) |=> !zc_q);

    // R7
    irq_with_zc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> zc_q);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> (!irq_q || zc_q));

endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
    import tmr_chan_pkg::*;
#(
    parameter int SHORT_DIV = 16,
    parameter int LONG_DIV  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ext_trig,
    input  logic              int_ack,
    output logic              term_pulse,
    output logic              irq_req,
    output logic [BYTE_W-1:0] vector
);

    chan_cfg_t         cfg;
    logic [BYTE_W-1:0] tc_q;
    logic              tc_load;
    logic              sw_stop;
    logic              edge_hit;
    logic              pre_tick;
    logic              timer_run;

    tmr_wr_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .vec_q   (vector),
        .tc_q    (tc_q),
        .tc_load (tc_load),
        .sw_stop (sw_stop)
    );

    tmr_edge_sel u_edge (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (ext_trig),
        .rise_sel (cfg.rise_sel),
        .edge_hit (edge_hit)
    );

    tmr_prescale #(.SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (timer_run),
        .long_pre (cfg.long_pre),
        .tick     (pre_tick)
    );

    tmr_downcount #(.CNT_W(BYTE_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .irq_en     (cfg.irq_en),
        .ext_count  (cfg.ext_count),
        .trig_start (cfg.trig_start),
        .edge_hit   (edge_hit),
        .pre_tick   (pre_tick),
        .tc_load    (tc_load),
        .tc_new     (wr_data),
        .tc_reload  (tc_q),
        .sw_stop    (sw_stop),
        .int_ack    (int_ack),
        .timer_run  (timer_run),
        .zc_q       (term_pulse),
        .irq_q      (irq_req)
    );

endmodule

// File: tb/tmr_chan_top_bench.sv
`timescale 1ns/1ps
module tmr_chan_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_trig = 1'b0;
    logic       int_ack = 1'b0;
    logic       term_pulse;
    logic       irq_req;
    logic [7:0] vector;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    tmr_chan_top u_tmr_chan_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ext_trig(ext_trig), .int_ack(int_ack),
        .term_pulse(term_pulse), .irq_req(irq_req), .vector(vector)
    );

    // ---- behavioural reference model ----
    int  m_mode;          // 0 stopped, 1 waiting for trigger, 2 counting
    int  m_left, m_reload, m_ticks;
    bit  m_ie, m_evt, m_long, m_rise, m_trig, m_expect_tc;
    bit  m_prev, m_zc, m_irq;
    bit [7:0] m_vec;

    always @(posedge clk) begin
        bit hit, step, hitzero;
        if (rst) begin
            m_mode = 0; m_left = 0; m_reload = 0; m_ticks = 0;
            {m_ie, m_evt, m_long, m_rise, m_trig, m_expect_tc} = '0;
            m_prev = 0; m_zc = 0; m_irq = 0; m_vec = 0;
        end else begin
            hit = m_rise ? (ext_trig && !m_prev) : (!ext_trig && m_prev);
            m_prev = ext_trig;
            step = 0;
            if (m_mode == 2 && m_evt) step = hit;
            else if (m_mode == 2) begin
                m_ticks++;
                if (m_ticks == (m_long ? 256 : 16)) begin step = 1; m_ticks = 0; end
            end else m_ticks = 0;
            if (m_mode != 2 || m_evt) m_ticks = 0;
            hitzero = step && (m_left == 1);
            m_zc = hitzero;
            if (hitzero && m_ie) m_irq = 1;
            else if (int_ack) m_irq = 0;
            if (step) m_left = hitzero ? ((m_reload == 0) ? 256 : m_reload) : m_left - 1;
            if (m_mode == 1 && hit) m_mode = 2;
            if (wr_en) begin
                if (m_expect_tc) begin
                    if (m_mode == 0) begin
                        m_left = (wr_data == 0) ? 256 : wr_data;
                        m_mode = (!m_evt && m_trig) ? 1 : 2;
                    end
                    m_reload = wr_data;
                    m_expect_tc = 0;
                end else if (wr_data[0]) begin
                    if (wr_data[1]) m_mode = 0;
                    m_ie = wr_data[7]; m_evt = wr_data[6]; m_long = wr_data[5];
                    m_rise = wr_data[4]; m_trig = wr_data[3];
                    m_expect_tc = wr_data[2];
                end else m_vec = wr_data;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (term_pulse !== m_zc || irq_req !== m_irq || vector !== m_vec) begin
                errors++;
                $display("FAIL %s model compare @%0d: zc=%b irq=%b vec=%h expected zc=%b irq=%b vec=%h",
                         cur_req, cycles, term_pulse, irq_req, vector, m_zc, m_irq, m_vec);
            end
        end
    end

    // ---- helpers ----
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // cycles from now until term_pulse seen (limit returns -1)
    task automatic gap(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (term_pulse) begin n = i; break; end
        end
    endtask

    task automatic count_pulses(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (term_pulse) n++;
        end
    endtask

    task automatic trig_toggle(input int times);
        for (int i = 0; i < times; i++) begin
            ext_trig = ~ext_trig;
            idle(2);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        idle(3);
        rst = 0;

        // R1: reset state, channel stopped
        cur_req = "R1";
        @(negedge clk);
        check("R1", "term_pulse after reset", term_pulse, 0);
        check("R1", "irq_req after reset", irq_req, 0);
        check("R1", "vector after reset", vector, 0);
        count_pulses(300, n);
        check("R1", "pulses while stopped", n, 0);

        // R2: vector write
        cur_req = "R2";
        wr(8'h42);
        check("R2", "vector", vector, 8'h42);

        // R4: interval, /16, N=5
        cur_req = "R4";
        wr(8'h07);           // interval, /16, reload follows, stop
        wr(8'h05);
        gap(200, n);
        check("R4", "first pulse delay /16 N=5", n, 80);
        @(negedge clk);
        check("R4", "pulse width one cycle", term_pulse, 0);
        gap(200, n);
        check("R4", "period /16 N=5", n, 79);
        // R3: reload byte with bit0=1 not taken as config/vector
        cur_req = "R3";
        wr(8'h07);
        wr(8'h03);           // reload 3, odd byte
        check("R3", "vector unchanged by reload byte", vector, 8'h42);
        gap(100, n);
        check("R3", "odd reload byte used as count 3", n, 48);
        // R4: /256, N=2
        cur_req = "R4";
        wr(8'h27);
        wr(8'h02);
        gap(1000, n);
        check("R4", "first pulse delay /256 N=2", n, 512);
        // R4: N=0 means 256 at /16
        wr(8'h07);
        wr(8'h00);
        gap(5000, n);
        check("R4", "first pulse delay /16 N=0", n, 4096);

        // R5: event mode rising, N=3
        cur_req = "R5";
        wr(8'h57);
        wr(8'h03);
        trig_toggle(4);      // two rising edges
        check("R5", "no pulse after 2 edges", term_pulse, 0);
        ext_trig = 1;        // third rising edge
        @(negedge clk);
        check("R5", "pulse after 3rd rising edge", term_pulse, 1);
        idle(2);
        ext_trig = 0;
        idle(2);
        // falling edges, N=2
        wr(8'h47);
        wr(8'h02);
        ext_trig = 1; idle(2);
        ext_trig = 0;        // falling #1
        idle(2);
        ext_trig = 1; idle(2);
        ext_trig = 0;        // falling #2
        @(negedge clk);
        check("R5", "pulse after 2nd falling edge", term_pulse, 1);
        idle(3);

        // R6: triggered interval start
        cur_req = "R6";
        wr(8'h1F);
        wr(8'h02);
        count_pulses(200, n);
        check("R6", "no pulse before trigger", n, 0);
        ext_trig = 1;
        gap(100, n);
        check("R6", "pulse after trigger", n, 1 + 32);
        ext_trig = 0;

        // R7: interrupts
        cur_req = "R7";
        wr(8'h87);
        wr(8'h02);
        gap(100, n);
        check("R7", "irq set with pulse", irq_req, 1);
        idle(5);
        check("R7", "irq held until ack", irq_req, 1);
        int_ack = 1;
        @(negedge clk);
        int_ack = 0;
        check("R7", "irq cleared by ack", irq_req, 0);
        wr(8'h07);
        wr(8'h02);
        gap(100, n);
        check("R7", "irq stays low when disabled", irq_req, 0);

        // R8: enabling after a zero-count is not retroactive
        cur_req = "R8";
        wr(8'h81);           // enable, keep running
        idle(3);
        check("R8", "no irq for earlier zero", irq_req, 0);
        gap(100, n);
        check("R8", "irq on next zero", irq_req, 1);
        int_ack = 1; @(negedge clk); int_ack = 0;

        // R9: software stop
        cur_req = "R9";
        wr(8'h03);
        count_pulses(300, n);
        check("R9", "pulses after stop", n, 0);
        wr(8'h07);
        wr(8'h01);
        gap(50, n);
        check("R9", "restart after reload", n, 16);

        // R10: reload while running
        cur_req = "R10";
        wr(8'h07);
        wr(8'h04);           // period 64
        idle(10);
        wr(8'h05);           // config, reload follows, no stop
        wr(8'h02);
        gap(100, n);
        check("R10", "current period kept", n, 64 - 12);
        gap(100, n);
        check("R10", "new period after reload", n, 32);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule